// File: doc/BRIEF.md
# Translated Load Pipeline with Fault Squashing

This block is the data-load path of a small out-of-order core. The issuing unit hands it a base, an offset, a load tag and a privilege flag. Address generation adds base and offset to form a 64-bit virtual address. In the same cycle it sends the set index to a 4-way, 64-set L1 data array and the virtual page number to an 8-entry fully associative TLB, so the cache read and the translation run in parallel. The L1 front end reads the tag, valid bit and addressed word of every way before the physical page is known. On the next cycle the back end compares each way's tag with the translated physical page, selects the matching way, and registers the response.

Faulting loads never return cached contents. A user-mode access to an upper-half address is stopped in address generation, and neither the TLB nor the L1 is looked up for it. TLB permission faults and TLB misses each carry their own fault code, and the data returned with them is zero. Test-only write ports preload the TLB entries and the cache lines. Refill, page walks, stores and coherence are not part of this block.

Top module: `load_xlate_path`

## Requirements
- R1: A request sampled with `req_valid` high in cycle n yields `rsp_valid` high in cycle n+2. A request may be presented every cycle, and a cycle with no request yields no response two cycles later.
- R2: `rsp_tag` equals the `req_tag` of the request that produced the response.
- R3: The virtual address is `req_base + req_off` modulo 2^64. Address bits [11:6] pick the set, bits [5:3] pick the 64-bit word in the 64-byte line, and bits [63:12] form the virtual page number.
- R4: If a valid TLB entry matches the page and the access is permitted, and a valid way of the set holds a tag equal to that entry's physical page number, then the response has `rsp_hit`=1, `rsp_fault`=0 and the addressed word of that way as data.
- R5: A user access (`req_user`=1) that hits a TLB entry marked supervisor-only returns `rsp_fault`=2, `rsp_hit`=0 and zero data, even when the line is cached.
- R6: A user access whose virtual address has bit 63 set returns `rsp_fault`=1, `rsp_hit`=0 and zero data, whatever the TLB and cache hold. A supervisor access (`req_user`=0) to the same address is translated normally.
- R7: If no valid TLB entry matches the page, the response has `rsp_fault`=3, `rsp_hit`=0 and zero data.
- R8: A translated, permitted access that matches no valid way (tag differs or line invalid) returns `rsp_fault`=0, `rsp_hit`=0 and zero data.
- R9: Reset clears every TLB entry and every cache line valid bit and drops `rsp_valid`. A load issued after reset with no preload reports `rsp_fault`=3.
- R10: While `rsp_valid` is low, `rsp_tag`, `rsp_hit`, `rsp_fault` and `rsp_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request strobe |
| req_tag | input | TAG_W | Load identifier echoed in the response |
| req_base | input | VA_W | Base operand of the address |
| req_off | input | VA_W | Offset operand of the address |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| rsp_valid | output | 1 | Response strobe |
| rsp_tag | output | TAG_W | Tag of the answered load |
| rsp_hit | output | 1 | Data came from a matching cache way |
| rsp_fault | output | 2 | 0 none, 1 early privilege, 2 TLB permission, 3 TLB miss |
| rsp_data | output | DATA_W | Loaded word, zero unless hit |
| tlb_wr_en | input | 1 | Preload one TLB entry |
| tlb_wr_idx | input | log2(TLB_N) | Entry index |
| tlb_wr_valid | input | 1 | Entry valid bit |
| tlb_wr_vpn | input | VA_W-12 | Virtual page number |
| tlb_wr_ppn | input | PA_W-12 | Physical page number |
| tlb_wr_sup | input | 1 | Entry is supervisor-only |
| l1_wr_en | input | 1 | Preload one cache word |
| l1_wr_set | input | 6 | Set index |
| l1_wr_way | input | log2(WAYS) | Way |
| l1_wr_word | input | 3 | Word within line |
| l1_wr_valid | input | 1 | Line valid bit |
| l1_wr_tag | input | PA_W-12 | Line physical tag |
| l1_wr_data | input | DATA_W | Word contents |

## Verification
The early privilege stop and the TLB's own verdict can both apply to the same load. The bench provokes this with user loads to an upper-half page that has a valid, permitted TLB entry and a cached line, and with user loads to an upper-half page that has no TLB entry at all. In both cases fault code 1 must win, with zero data, and a supervisor load to the same address must still translate. The same overlap occurs between a TLB permission fault and a cache hit: a user load to a supervisor-only page whose line is cached must return code 2 and zero rather than the cached word. The loads run back to back, so each check also confirms that a stopped access leaves the neighbouring responses unaffected.

// File: rtl/load_xlate_path.sv
module load_xlate_path #(
  parameter int VA_W      = 64,
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int WAYS      = 4,
  parameter int TLB_N     = 8,
  parameter int DATA_W    = 64,
  parameter int TAG_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [TAG_W-1:0]              req_tag,
  input  logic [VA_W-1:0]               req_base,
  input  logic [VA_W-1:0]               req_off,
  input  logic                          req_user,
  output logic                          rsp_valid,
  output logic [TAG_W-1:0]              rsp_tag,
  output logic                          rsp_hit,
  output logic [1:0]                    rsp_fault,
  output logic [DATA_W-1:0]             rsp_data,
  input  logic                          tlb_wr_en,
  input  logic [$clog2(TLB_N)-1:0]      tlb_wr_idx,
  input  logic                          tlb_wr_valid,
  input  logic [VA_W-PAGE_BITS-1:0]     tlb_wr_vpn,
  input  logic [PA_W-PAGE_BITS-1:0]     tlb_wr_ppn,
  input  logic                          tlb_wr_sup,
  input  logic                          l1_wr_en,
  input  logic [PAGE_BITS-LINE_BITS-1:0] l1_wr_set,
  input  logic [$clog2(WAYS)-1:0]       l1_wr_way,
  input  logic [LINE_BITS-$clog2(DATA_W/8)-1:0] l1_wr_word,
  input  logic                          l1_wr_valid,
  input  logic [PA_W-PAGE_BITS-1:0]     l1_wr_tag,
  input  logic [DATA_W-1:0]             l1_wr_data
);
  localparam int SET_BITS  = PAGE_BITS - LINE_BITS;
  localparam int SETS      = 1 << SET_BITS;
  localparam int WB_BITS   = $clog2(DATA_W / 8);
  localparam int WORD_BITS = LINE_BITS - WB_BITS;
  localparam int WAY_BITS  = $clog2(WAYS);
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PPN_W     = PA_W - PAGE_BITS;
  localparam int LINES     = WAYS * SETS;
  localparam int WORDS_ALL = LINES << WORD_BITS;

  localparam logic [1:0] F_NONE = 2'd0;
  localparam logic [1:0] F_PRIV = 2'd1;
  localparam logic [1:0] F_PERM = 2'd2;
  localparam logic [1:0] F_MISS = 2'd3;

  // address generation
  logic [VA_W-1:0] va;
  assign va = req_base + req_off;

  logic                 priv_stop, look;
  logic [SET_BITS-1:0]  set_idx;
  logic [WORD_BITS-1:0] word_idx;
  logic [VPN_W-1:0]     vpn;
  assign priv_stop = req_user & va[VA_W-1];
  assign look      = req_valid & ~priv_stop;
  assign set_idx   = va[PAGE_BITS-1:LINE_BITS];
  assign word_idx  = va[LINE_BITS-1:WB_BITS];
  assign vpn       = va[VA_W-1:PAGE_BITS];

  // TLB storage
  logic [TLB_N-1:0] tlb_v;
  logic [VPN_W-1:0] tlb_vpn [TLB_N];
  logic [PPN_W-1:0] tlb_ppn [TLB_N];
  logic [TLB_N-1:0] tlb_sup;

  always_ff @(posedge clk) begin
    if (!rst_n)         tlb_v <= '0;
    else if (tlb_wr_en) tlb_v[tlb_wr_idx] <= tlb_wr_valid;
  end

  always_ff @(posedge clk) begin
    if (tlb_wr_en) begin
      tlb_vpn[tlb_wr_idx] <= tlb_wr_vpn;
      tlb_ppn[tlb_wr_idx] <= tlb_wr_ppn;
      tlb_sup[tlb_wr_idx] <= tlb_wr_sup;
    end
  end

  logic             t_hit, t_sup;
  logic [PPN_W-1:0] t_ppn;
  always_comb begin
    t_hit = 1'b0;
    t_sup = 1'b0;
    t_ppn = '0;
    for (int i = TLB_N - 1; i >= 0; i--) begin
      if (tlb_v[i] && tlb_vpn[i] == vpn) begin
        t_hit = 1'b1;
        t_sup = tlb_sup[i];
        t_ppn = tlb_ppn[i];
      end
    end
  end

  // L1 arrays
  logic [WAYS-1:0]   l1_v   [SETS];
  logic [PPN_W-1:0]  l1_tag [LINES];
  logic [DATA_W-1:0] l1_dat [WORDS_ALL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) l1_v[s] <= '0;
    end else if (l1_wr_en) begin
      l1_v[l1_wr_set][l1_wr_way] <= l1_wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (l1_wr_en) begin
      l1_tag[{l1_wr_way, l1_wr_set}]             <= l1_wr_tag;
      l1_dat[{l1_wr_way, l1_wr_set, l1_wr_word}] <= l1_wr_data;
    end
  end

  // stage 1: front-end read of every way and translation result
  logic              s1_valid, s1_stop, s1_user;
  logic [TAG_W-1:0]  s1_tag;
  logic              s1_thit, s1_tsup;
  logic [PPN_W-1:0]  s1_ppn;
  logic [WAYS-1:0]   s1_wv;
  logic [PPN_W-1:0]  s1_wtag [WAYS];
  logic [DATA_W-1:0] s1_wdat [WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_stop  <= 1'b0;
      s1_user  <= 1'b0;
      s1_tag   <= '0;
    end else begin
      s1_valid <= req_valid;
      s1_stop  <= priv_stop;
      s1_user  <= req_user;
      s1_tag   <= req_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (look) begin
      s1_thit <= t_hit;
      s1_tsup <= t_sup;
      s1_ppn  <= t_ppn;
      for (int w = 0; w < WAYS; w++) begin
        s1_wv[w]   <= l1_v[set_idx][w];
        s1_wtag[w] <= l1_tag[{WAY_BITS'(w), set_idx}];
        s1_wdat[w] <= l1_dat[{WAY_BITS'(w), set_idx, word_idx}];
      end
    end
  end

  // stage 2: back-end way select and fault squashing
  logic              way_any;
  logic [DATA_W-1:0] way_dat;
  always_comb begin
    way_any = 1'b0;
    way_dat = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (s1_wv[w] && s1_wtag[w] == s1_ppn) begin
        way_any = 1'b1;
        way_dat = s1_wdat[w];
      end
    end
  end

  logic [1:0] fcode;
  assign fcode = s1_stop                ? F_PRIV :
                 !s1_thit               ? F_MISS :
                 (s1_user && s1_tsup)   ? F_PERM : F_NONE;

  logic hit_n;
  assign hit_n = s1_valid && fcode == F_NONE && way_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_hit   <= 1'b0;
      rsp_fault <= F_NONE;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= s1_valid;
      rsp_tag   <= s1_valid ? s1_tag : '0;
      rsp_hit   <= hit_n;
      rsp_fault <= s1_valid ? fcode : F_NONE;
      rsp_data  <= hit_n ? way_dat : '0;
    end
  end
endmodule

// File: rtl/load_xlate_path_chk.sv
module load_xlate_path_chk #(
  parameter int VA_W   = 64,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [TAG_W-1:0]  req_tag,
  input logic [VA_W-1:0]   req_base,
  input logic [VA_W-1:0]   req_off,
  input logic              req_user,
  input logic              rsp_valid,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic              rsp_hit,
  input logic [1:0]        rsp_fault,
  input logic [DATA_W-1:0] rsp_data
);
  logic [VA_W-1:0] va_c;
  assign va_c = req_base + req_off;

  // R1
  lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 rsp_valid);

  // R1
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ##2 !rsp_valid);

  // R2
  tag_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_tag == $past(req_tag, 2));

  // R6
  early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && va_c[VA_W-1]) |-> ##2 (rsp_fault == 2'd1));

  // R6
  sup_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_user) |-> ##2 (rsp_fault != 2'd1));

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_data == '0 && !rsp_hit));

  // R4
  hit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_valid && rsp_fault == 2'd0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_data == '0 && !rsp_hit && rsp_fault == 2'd0 && rsp_tag == '0));
endmodule

bind load_xlate_path load_xlate_path_chk #(.VA_W(VA_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
  .req_base(req_base), .req_off(req_off), .req_user(req_user),
  .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_hit(rsp_hit),
  .rsp_fault(rsp_fault), .rsp_data(rsp_data)
);

// File: tb/load_xlate_path_tb.sv
`timescale 1ns/1ps
module load_xlate_path_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_tag = '0;
  logic [63:0] req_base = '0, req_off = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [3:0]  rsp_tag;
  logic [1:0]  rsp_fault;
  logic [63:0] rsp_data;
  logic        tlb_wr_en = 0, tlb_wr_valid = 0, tlb_wr_sup = 0;
  logic [2:0]  tlb_wr_idx = '0;
  logic [51:0] tlb_wr_vpn = '0;
  logic [27:0] tlb_wr_ppn = '0;
  logic        l1_wr_en = 0, l1_wr_valid = 0;
  logic [5:0]  l1_wr_set = '0;
  logic [1:0]  l1_wr_way = '0;
  logic [2:0]  l1_wr_word = '0;
  logic [27:0] l1_wr_tag = '0;
  logic [63:0] l1_wr_data = '0;

  always #2 clk = ~clk;

  load_xlate_path u_dut (.*);

  int nchk = 0, nfail = 0;
  string phase = "";

  bit          mt_v [8];
  logic [51:0] mt_vpn [8];
  logic [27:0] mt_ppn [8];
  bit          mt_sup [8];
  bit          mc_v [4][64];
  logic [27:0] mc_tag [4][64];
  logic [63:0] mc_dat [4][64][8];

  logic [63:0] ld_va [512];
  bit          ld_user [512];
  int          n_ld = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s%s actual=%h expected=%h", phase, req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  function automatic logic [51:0] vpn_of(int e);
    if (e < 6)  return 52'h100 + 52'(e);
    if (e == 6) return 52'h8000000000040;
    return 52'h107;
  endfunction

  function automatic int set_of(int e);
    return (e * 9 + 5) % 64;
  endfunction

  // expected response computed from R3..R8
  task automatic model(input logic [63:0] va, input bit user,
                       output bit hit, output logic [1:0] f, output logic [63:0] d);
    int te = -1;
    hit = 0; f = 0; d = '0;
    if (user && va[63]) begin f = 1; return; end
    for (int i = 0; i < 8; i++)
      if (te < 0 && mt_v[i] && mt_vpn[i] == va[63:12]) te = i;
    if (te < 0) begin f = 3; return; end
    if (user && mt_sup[te]) begin f = 2; return; end
    for (int w = 0; w < 4; w++)
      if (mc_v[w][va[11:6]] && mc_tag[w][va[11:6]] == mt_ppn[te]) begin
        hit = 1; d = mc_dat[w][va[11:6]][va[5:3]];
      end
  endtask

  task automatic tlb_put(int i, bit v, logic [51:0] vp, logic [27:0] pp, bit s);
    @(negedge clk);
    tlb_wr_en = 1; tlb_wr_idx = 3'(i); tlb_wr_valid = v;
    tlb_wr_vpn = vp; tlb_wr_ppn = pp; tlb_wr_sup = s;
    mt_v[i] = v; mt_vpn[i] = vp; mt_ppn[i] = pp; mt_sup[i] = s;
    @(negedge clk);
    tlb_wr_en = 0;
  endtask

  task automatic l1_put(int s, int w, int wd, bit v, logic [27:0] tg, logic [63:0] dt);
    @(negedge clk);
    l1_wr_en = 1; l1_wr_set = 6'(s); l1_wr_way = 2'(w); l1_wr_word = 3'(wd);
    l1_wr_valid = v; l1_wr_tag = tg; l1_wr_data = dt;
    mc_v[w][s] = v; mc_tag[w][s] = tg; mc_dat[w][s][wd] = dt;
    @(negedge clk);
    l1_wr_en = 0;
  endtask

  task automatic fill_line(int s, int w, bit v, logic [27:0] tg, logic [63:0] seed);
    for (int wd = 0; wd < 8; wd++) l1_put(s, w, wd, v, tg, seed ^ 64'(wd * 8'h11));
  endtask

  task automatic add_ld(logic [63:0] va, bit user);
    ld_va[n_ld] = va; ld_user[n_ld] = user; n_ld++;
  endtask

  task automatic check_rsp(int j);
    bit hit; logic [1:0] f; logic [63:0] d; string lab;
    model(ld_va[j], ld_user[j], hit, f, d);
    lab = (f == 1) ? "R6" : (f == 2) ? "R5" : (f == 3) ? "R7" : hit ? "R4/R3" : "R8";
    check("R1 rsp_valid", 64'(rsp_valid), 64'd1);
    check("R2 rsp_tag", 64'(rsp_tag), 64'(j % 16));
    check({lab, " fault"}, 64'(rsp_fault), 64'(f));
    check({lab, " hit"}, 64'(rsp_hit), 64'(hit));
    check({lab, " data"}, rsp_data, d);
  endtask

  // back-to-back issue, one load per cycle, response checked two cycles later (R1)
  task automatic run_loads();
    logic [63:0] off;
    for (int k = 0; k < n_ld + 2; k++) begin
      @(negedge clk);
      if (k >= 2) check_rsp(k - 2);
      if (k < n_ld) begin
        case (k % 3)
          0: off = 64'd0;
          1: off = 64'h0000_0123_4567_8ff8;
          default: off = -64'd8;
        endcase
        req_valid = 1; req_tag = 4'(k); req_user = ld_user[k];
        req_off = off; req_base = ld_va[k] - off;
      end else begin
        req_valid = 0; req_tag = '0; req_base = '0; req_off = '0; req_user = 0;
      end
    end
    @(negedge clk);
    check("R1/R10 idle rsp_valid", 64'(rsp_valid), 64'd0);
    check("R10 idle rsp_data", rsp_data, 64'd0);
    n_ld = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R10 rsp_fault after reset", 64'(rsp_fault), 64'd0);
    rst_n = 1;
    phase = "R9 ";
    add_ld(64'h0000_0000_0010_0140, 0);
    add_ld(64'h0000_0000_0010_5000, 1);
    run_loads();
    phase = "";

    for (int e = 0; e < 8; e++)
      tlb_put(e, e != 7, vpn_of(e), (e == 6) ? 28'h0C0DE : 28'h0AB00 + 28'(e * 3), (e < 6) ? e[0] : 1'b0);
    for (int e = 0; e < 7; e++) begin
      fill_line(set_of(e), e % 4, 1, mt_ppn[e], 64'hD00D_0000_0000_0000 | (64'(e) << 16));
      fill_line(set_of(e), (e + 1) % 4, 1, mt_ppn[e] ^ 28'h1, 64'hBAD0_0000_0000_0000 | 64'(e));
    end
    fill_line(60, 2, 0, mt_ppn[0], 64'h5A5A_5A5A_0000_0000);

    for (int e = 0; e < 8; e++)
      for (int u = 0; u < 2; u++)
        for (int wd = 0; wd < 8; wd++)
          add_ld({vpn_of(e), 6'(set_of(e)), 3'(wd), 3'b0}, u[0]);
    for (int e = 0; e < 7; e++)
      for (int u = 0; u < 2; u++)
        add_ld({vpn_of(e), 6'((set_of(e) + 1) % 64), 3'd3, 3'b0}, u[0]);
    add_ld({vpn_of(0), 6'd60, 3'd1, 3'b0}, 0);
    add_ld(64'hFFFF_8000_0000_0040, 1);
    add_ld(64'hFFFF_8000_0000_0040, 0);
    run_loads();
    summary();
  end
endmodule